// File: doc/BRIEF.md
# Multicycle Processor Control Sequencer

This block is the control state machine of a 32-bit multicycle processor. It reads the 6-bit opcode held in the instruction register and steps the datapath through a short sequence of states for each instruction. In every state it drives the memory strobes, the register load enables, the multiplexer selects and the ALU operation class. The register file, the ALU, the memory and the datapath registers sit outside the block. ALUOut is assumed to load on every clock.

There are eleven states. `ST_FETCH` reads the instruction and advances the PC by 4. `ST_DECODE` latches A and B and precomputes the branch target. The remaining states are:

- `ST_LD_ADDR` and `ST_ST_ADDR`: address calculation for loads and stores.
- `ST_LD_READ`: memory read for a load.
- `ST_LD_WB`: load write-back.
- `ST_ST_WRITE`: memory write for a store.
- `ST_ALU_EXEC` and `ST_ALU_WB`: register-register execute and write-back.
- `ST_BR_DONE`: conditional branch.
- `ST_JMP_DONE`: jump.

The transitions are as follows:

- `ST_FETCH` always goes to `ST_DECODE`.
- `ST_DECODE` branches on the instruction kind. Load goes to `ST_LD_ADDR`, store to `ST_ST_ADDR`, register-register to `ST_ALU_EXEC`, branch to `ST_BR_DONE` and jump to `ST_JMP_DONE`. Any other opcode returns to `ST_FETCH`.
- `ST_LD_ADDR` goes to `ST_LD_READ`, which goes to `ST_LD_WB`.
- `ST_ST_ADDR` goes to `ST_ST_WRITE`.
- `ST_ALU_EXEC` goes to `ST_ALU_WB`.
- `ST_LD_WB`, `ST_ST_WRITE`, `ST_ALU_WB`, `ST_BR_DONE` and `ST_JMP_DONE` all return to `ST_FETCH`.

The synchronous reset forces `ST_FETCH`.

Top module: `mcc_ctrl`

## Requirements
- R1: While `rst` is high at a rising edge, the next state is `ST_FETCH`. The cycle after reset is released therefore shows the fetch outputs.
- R2: In `ST_FETCH` the block drives the following: `mem_rd`=1, `addr_sel`=0 (PC), `ir_load`=1 and `pc_load`=1 with `pc_src`=00 (ALU result). The ALU sources are `alu_a_sel`=0 (PC) and `alu_b_sel`=01 (constant 4), with `alu_class`=00 (add). All other outputs are 0.
- R3: In `ST_DECODE`, whatever the opcode, the block drives `alu_a_sel`=0 and `alu_b_sel`=11 (immediate shifted left by 2) with `alu_class`=00. Every other output is 0.
- R4: Opcode 000000 (register-register) takes 4 cycles.
  - The execute cycle drives `alu_a_sel`=1 (A), `alu_b_sel`=00 (B) and `alu_class`=10 (function field).
  - The write-back cycle drives `rf_wr`=1, `rf_dst_sel`=1 (bits 15:11) and `rf_data_sel`=0 (ALUOut).
- R5: Opcode 100011 (load) takes 5 cycles.
  - The address cycle drives `alu_a_sel`=1, `alu_b_sel`=10 (sign-extended immediate) and `alu_class`=00.
  - The read cycle drives `mem_rd`=1 and `addr_sel`=1 (ALUOut).
  - The write-back cycle drives `rf_wr`=1, `rf_dst_sel`=0 (bits 20:16) and `rf_data_sel`=1 (memory data).
- R6: Opcode 101011 (store) takes 4 cycles. It uses the same address cycle as a load, followed by a cycle with `mem_wr`=1 and `addr_sel`=1.
- R7: Opcode 000100 (branch-if-equal) takes 3 cycles. Its last cycle drives `alu_a_sel`=1, `alu_b_sel`=00, `alu_class`=01 (subtract), `pc_cond_load`=1 and `pc_src`=01 (ALUOut).
- R8: Opcode 000010 (jump) takes 3 cycles. Its last cycle drives `pc_load`=1 and `pc_src`=10 (jump target), with all else 0.
- R9: Any other opcode returns from `ST_DECODE` to `ST_FETCH`. It completes in 2 cycles, with no memory write, no register write and no PC write outside fetch.
- R10: `mem_rd` and `mem_wr` are never both 1. `pc_load` and `pc_cond_load` are never both 1.
- R11: The opcode is consulted only in `ST_DECODE`. Changing it in any later state of an instruction does not alter that instruction's sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| opcode | input | 6 | Opcode field from the instruction register |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| addr_sel | output | 1 | Memory address: 0 PC, 1 ALUOut |
| ir_load | output | 1 | Instruction register load |
| pc_load | output | 1 | Unconditional PC load |
| pc_cond_load | output | 1 | PC load when the ALU reports equality |
| pc_src | output | 2 | PC source: 00 ALU result, 01 ALUOut, 10 jump target |
| rf_wr | output | 1 | Register file write |
| rf_dst_sel | output | 1 | Destination: 0 bits 20:16, 1 bits 15:11 |
| rf_data_sel | output | 1 | Write data: 0 ALUOut, 1 memory data register |
| alu_a_sel | output | 1 | ALU A operand: 0 PC, 1 register A |
| alu_b_sel | output | 2 | ALU B operand: 00 B, 01 four, 10 immediate, 11 immediate shifted by 2 |
| alu_class | output | 2 | ALU class: 00 add, 01 subtract, 10 function field |

## Verification
Each of the five legal opcodes is run through its complete sequence, and every cycle's full output vector is compared with the expected one. This separates the sequences by both their length and their per-state controls. Two different illegal opcodes confirm the short return to fetch. Back-to-back instructions of different kinds show that each one starts from a clean fetch. A load is also run with the opcode switched to jump and store during its later states, which shows that only the decode cycle looks at the opcode.

// File: rtl/mcc_pkg.sv
package mcc_pkg;

    typedef enum logic [3:0] {
        ST_FETCH    = 4'd0,
        ST_DECODE   = 4'd1,
        ST_LD_ADDR  = 4'd2,
        ST_ST_ADDR  = 4'd3,
        ST_LD_READ  = 4'd4,
        ST_LD_WB    = 4'd5,
        ST_ST_WRITE = 4'd6,
        ST_ALU_EXEC = 4'd7,
        ST_ALU_WB   = 4'd8,
        ST_BR_DONE  = 4'd9,
        ST_JMP_DONE = 4'd10
    } mcc_state_e;

    typedef enum logic [2:0] {
        K_ALU    = 3'd0,
        K_LOAD   = 3'd1,
        K_STORE  = 3'd2,
        K_BRANCH = 3'd3,
        K_JUMP   = 3'd4,
        K_OTHER  = 3'd5
    } mcc_kind_e;

    typedef enum logic [1:0] {
        CLS_ADD  = 2'b00,
        CLS_SUB  = 2'b01,
        CLS_FUNC = 2'b10
    } alu_class_e;

    typedef enum logic [1:0] {
        BSEL_REG    = 2'b00,
        BSEL_FOUR   = 2'b01,
        BSEL_IMM    = 2'b10,
        BSEL_IMM_SH = 2'b11
    } bsel_e;

    typedef enum logic [1:0] {
        PCS_ALU  = 2'b00,
        PCS_OUT  = 2'b01,
        PCS_JUMP = 2'b10
    } pcsrc_e;

    typedef struct packed {
        logic       mem_rd;
        logic       mem_wr;
        logic       addr_sel;
        logic       ir_load;
        logic       pc_load;
        logic       pc_cond_load;
        pcsrc_e     pc_src;
        logic       rf_wr;
        logic       rf_dst_sel;
        logic       rf_data_sel;
        logic       alu_a_sel;
        bsel_e      alu_b_sel;
        alu_class_e alu_class;
    } mcc_ctl_t;

endpackage

// File: rtl/mcc_opclass.sv
module mcc_opclass
    import mcc_pkg::*;
#(
    parameter int          OP_W      = 6,
    parameter logic [OP_W-1:0] OP_RR  = 6'b000000,
    parameter logic [OP_W-1:0] OP_LD  = 6'b100011,
    parameter logic [OP_W-1:0] OP_ST  = 6'b101011,
    parameter logic [OP_W-1:0] OP_BEQ = 6'b000100,
    parameter logic [OP_W-1:0] OP_JMP = 6'b000010
) (
    input  logic [OP_W-1:0] opcode,
    output mcc_kind_e       kind
);

    always_comb begin
        if (opcode == OP_RR)        kind = K_ALU;
        else if (opcode == OP_LD)   kind = K_LOAD;
        else if (opcode == OP_ST)   kind = K_STORE;
        else if (opcode == OP_BEQ)  kind = K_BRANCH;
        else if (opcode == OP_JMP)  kind = K_JUMP;
        else                        kind = K_OTHER;
    end

endmodule

// File: rtl/mcc_next_state.sv
module mcc_next_state
    import mcc_pkg::*;
(
    input  mcc_state_e state,
    input  mcc_kind_e  kind,
    output mcc_state_e next
);

    always_comb begin
        next = ST_FETCH;
        unique case (state)
            ST_FETCH:    next = ST_DECODE;
            ST_DECODE: begin
                unique case (kind)
                    K_ALU:    next = ST_ALU_EXEC;
                    K_LOAD:   next = ST_LD_ADDR;
                    K_STORE:  next = ST_ST_ADDR;
                    K_BRANCH: next = ST_BR_DONE;
                    K_JUMP:   next = ST_JMP_DONE;
                    default:  next = ST_FETCH;
                endcase
            end
            ST_LD_ADDR:  next = ST_LD_READ;
            ST_LD_READ:  next = ST_LD_WB;
            ST_ST_ADDR:  next = ST_ST_WRITE;
            ST_ALU_EXEC: next = ST_ALU_WB;
            ST_LD_WB,
            ST_ST_WRITE,
            ST_ALU_WB,
            ST_BR_DONE,
            ST_JMP_DONE: next = ST_FETCH;
            default:     next = ST_FETCH;
        endcase
    end

endmodule

// File: rtl/mcc_out_decode.sv
module mcc_out_decode
    import mcc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  mcc_state_e state,
    output mcc_ctl_t   ctl
);

    always_comb begin
        ctl = '0;
        unique case (state)
            ST_FETCH: begin
                ctl.mem_rd    = 1'b1;
                ctl.ir_load   = 1'b1;
                ctl.pc_load   = 1'b1;
                ctl.pc_src    = PCS_ALU;
                ctl.alu_b_sel = BSEL_FOUR;
                ctl.alu_class = CLS_ADD;
            end
            ST_DECODE: begin
                ctl.alu_b_sel = BSEL_IMM_SH;
                ctl.alu_class = CLS_ADD;
            end
            ST_LD_ADDR,
            ST_ST_ADDR: begin
                ctl.alu_a_sel = 1'b1;
                ctl.alu_b_sel = BSEL_IMM;
                ctl.alu_class = CLS_ADD;
            end
            ST_LD_READ: begin
                ctl.mem_rd   = 1'b1;
                ctl.addr_sel = 1'b1;
            end
            ST_LD_WB: begin
                ctl.rf_wr       = 1'b1;
                ctl.rf_data_sel = 1'b1;
            end
            ST_ST_WRITE: begin
                ctl.mem_wr   = 1'b1;
                ctl.addr_sel = 1'b1;
            end
            ST_ALU_EXEC: begin
                ctl.alu_a_sel = 1'b1;
                ctl.alu_b_sel = BSEL_REG;
                ctl.alu_class = CLS_FUNC;
            end
            ST_ALU_WB: begin
                ctl.rf_wr      = 1'b1;
                ctl.rf_dst_sel = 1'b1;
            end
            ST_BR_DONE: begin
                ctl.alu_a_sel    = 1'b1;
                ctl.alu_b_sel    = BSEL_REG;
                ctl.alu_class    = CLS_SUB;
                ctl.pc_cond_load = 1'b1;
                ctl.pc_src       = PCS_OUT;
            end
            ST_JMP_DONE: begin
                ctl.pc_load = 1'b1;
                ctl.pc_src  = PCS_JUMP;
            end
            default: ctl = '0;
        endcase
    end

    // R10
    mem_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(ctl.mem_rd && ctl.mem_wr));

    // R10
    pc_write_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(ctl.pc_load && ctl.pc_cond_load));

endmodule

// File: rtl/mcc_ctrl.sv
module mcc_ctrl
    import mcc_pkg::*;
#(
    parameter int OP_W = 6
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [OP_W-1:0] opcode,
    output logic            mem_rd,
    output logic            mem_wr,
    output logic            addr_sel,
    output logic            ir_load,
    output logic            pc_load,
    output logic            pc_cond_load,
    output logic [1:0]      pc_src,
    output logic            rf_wr,
    output logic            rf_dst_sel,
    output logic            rf_data_sel,
    output logic            alu_a_sel,
    output logic [1:0]      alu_b_sel,
    output logic [1:0]      alu_class
);

    mcc_state_e state_q;
    mcc_state_e state_d;
    mcc_kind_e  kind;
    mcc_ctl_t   ctl;

    mcc_opclass #(.OP_W(OP_W)) u_opclass (
        .opcode (opcode),
        .kind   (kind)
    );

    mcc_next_state u_next (
        .state (state_q),
        .kind  (kind),
        .next  (state_d)
    );

    mcc_out_decode u_out (
        .clk   (clk),
        .rst   (rst),
        .state (state_q),
        .ctl   (ctl)
    );

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_FETCH;
        else     state_q <= state_d;
    end

    always_comb begin
        mem_rd       = ctl.mem_rd;
        mem_wr       = ctl.mem_wr;
        addr_sel     = ctl.addr_sel;
        ir_load      = ctl.ir_load;
        pc_load      = ctl.pc_load;
        pc_cond_load = ctl.pc_cond_load;
        pc_src       = ctl.pc_src;
        rf_wr        = ctl.rf_wr;
        rf_dst_sel   = ctl.rf_dst_sel;
        rf_data_sel  = ctl.rf_data_sel;
        alu_a_sel    = ctl.alu_a_sel;
        alu_b_sel    = ctl.alu_b_sel;
        alu_class    = ctl.alu_class;
    end

    // R1
    reset_fetch_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> ir_load);

    // R2
    fetch_to_decode_chk: assert property (@(posedge clk) disable iff (rst)
        ir_load |=> (!ir_load && alu_b_sel == 2'b11));

    // R4
    wb_then_fetch_chk: assert property (@(posedge clk) disable iff (rst)
        rf_wr |=> ir_load);

    // R7
    br_then_fetch_chk: assert property (@(posedge clk) disable iff (rst)
        pc_cond_load |=> ir_load);

    // R11
    ld_addr_seq_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_LD_ADDR) |=> (state_q == ST_LD_READ));

    // R11
    st_addr_seq_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_ST_ADDR) |=> (state_q == ST_ST_WRITE));

endmodule

// File: tb/mcc_ctrl_bench.sv
module mcc_ctrl_bench;

    localparam int E_FETCH = 0, E_DECODE = 1, E_ADDR = 2, E_LD_READ = 3,
                   E_LD_WB = 4, E_ST_WR = 5, E_ALU_EX = 6, E_ALU_WB = 7,
                   E_BR = 8, E_JMP = 9;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [5:0] opcode = 6'b000000;
    logic mem_rd, mem_wr, addr_sel, ir_load, pc_load, pc_cond_load;
    logic [1:0] pc_src;
    logic rf_wr, rf_dst_sel, rf_data_sel, alu_a_sel;
    logic [1:0] alu_b_sel, alu_class;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    mcc_ctrl u_mcc_ctrl (
        .clk(clk), .rst(rst), .opcode(opcode),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .addr_sel(addr_sel),
        .ir_load(ir_load), .pc_load(pc_load), .pc_cond_load(pc_cond_load),
        .pc_src(pc_src), .rf_wr(rf_wr), .rf_dst_sel(rf_dst_sel),
        .rf_data_sel(rf_data_sel), .alu_a_sel(alu_a_sel),
        .alu_b_sel(alu_b_sel), .alu_class(alu_class)
    );

    // order: mem_rd mem_wr addr_sel ir_load pc_load pc_cond_load pc_src(2)
    //        rf_wr rf_dst_sel rf_data_sel alu_a_sel alu_b_sel(2) alu_class(2)
    function automatic logic [15:0] expect_vec(input int st);
        case (st)
            E_FETCH:   return 16'b1_0_0_1_1_0_00_0_0_0_0_01_00;
            E_DECODE:  return 16'b0_0_0_0_0_0_00_0_0_0_0_11_00;
            E_ADDR:    return 16'b0_0_0_0_0_0_00_0_0_0_1_10_00;
            E_LD_READ: return 16'b1_0_1_0_0_0_00_0_0_0_0_00_00;
            E_LD_WB:   return 16'b0_0_0_0_0_0_00_1_0_1_0_00_00;
            E_ST_WR:   return 16'b0_1_1_0_0_0_00_0_0_0_0_00_00;
            E_ALU_EX:  return 16'b0_0_0_0_0_0_00_0_0_0_1_00_10;
            E_ALU_WB:  return 16'b0_0_0_0_0_0_00_1_1_0_0_00_00;
            E_BR:      return 16'b0_0_0_0_0_1_01_0_0_0_1_00_01;
            E_JMP:     return 16'b0_0_0_0_1_0_10_0_0_0_0_00_00;
            default:   return 16'hFFFF;
        endcase
    endfunction

    function automatic logic [15:0] actual_vec();
        return {mem_rd, mem_wr, addr_sel, ir_load, pc_load, pc_cond_load,
                pc_src, rf_wr, rf_dst_sel, rf_data_sel, alu_a_sel,
                alu_b_sel, alu_class};
    endfunction

    task automatic check(input int st, input string req);
        logic [15:0] a;
        logic [15:0] e;
        a = actual_vec();
        e = expect_vec(st);
        tests++;
        if (a !== e) begin
            fails++;
            $display("FAIL %s: outputs %b expected %b", req, a, e);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) step();
        rst = 1'b0;
        check(E_FETCH, "R1 reset");
    endtask

    task automatic t_alu();
        opcode = 6'b000000;
        check(E_FETCH, "R2 fetch");
        step(); check(E_DECODE, "R3 decode rr");
        step(); check(E_ALU_EX, "R4 exec");
        step(); check(E_ALU_WB, "R4 wb");
        step(); check(E_FETCH, "R4 back to fetch");
    endtask

    task automatic t_load(input bit scramble);
        opcode = 6'b100011;
        check(E_FETCH, "R2 fetch");
        step(); check(E_DECODE, "R3 decode ld");
        step();
        if (scramble) opcode = 6'b000010;
        check(E_ADDR, scramble ? "R11 ld addr" : "R5 ld addr");
        step();
        if (scramble) opcode = 6'b101011;
        check(E_LD_READ, scramble ? "R11 ld read" : "R5 ld read");
        step();
        if (scramble) opcode = 6'b000100;
        check(E_LD_WB, scramble ? "R11 ld wb" : "R5 ld wb");
        step(); check(E_FETCH, scramble ? "R11 back to fetch" : "R5 back to fetch");
    endtask

    task automatic t_store();
        opcode = 6'b101011;
        check(E_FETCH, "R2 fetch");
        step(); check(E_DECODE, "R3 decode st");
        step(); check(E_ADDR, "R6 st addr");
        step(); check(E_ST_WR, "R6 st write");
        step(); check(E_FETCH, "R6 back to fetch");
    endtask

    task automatic t_branch();
        opcode = 6'b000100;
        check(E_FETCH, "R2 fetch");
        step(); check(E_DECODE, "R3 decode beq");
        step(); check(E_BR, "R7 branch");
        step(); check(E_FETCH, "R7 back to fetch");
    endtask

    task automatic t_jump();
        opcode = 6'b000010;
        check(E_FETCH, "R2 fetch");
        step(); check(E_DECODE, "R3 decode jump");
        step(); check(E_JMP, "R8 jump");
        step(); check(E_FETCH, "R8 back to fetch");
    endtask

    task automatic t_unknown(input logic [5:0] op);
        opcode = op;
        check(E_FETCH, "R2 fetch");
        step(); check(E_DECODE, "R9 decode illegal");
        step(); check(E_FETCH, "R9 illegal returns");
    endtask

    task automatic t_exclusive();
        // R10: memory strobes and PC loads never overlap across a mixed run
        int bad = 0;
        opcode = 6'b100011;
        for (int i = 0; i < 20; i++) begin
            if ((mem_rd && mem_wr) || (pc_load && pc_cond_load)) bad++;
            if (i == 6) opcode = 6'b101011;
            if (i == 12) opcode = 6'b000100;
            step();
        end
        tests++;
        if (bad != 0) begin
            fails++;
            $display("FAIL R10: overlapping cycles %0d expected 0", bad);
        end
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not end, expected completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin : main
        t_reset();
        t_alu();
        t_load(1'b0);
        t_store();
        t_branch();
        t_jump();
        t_unknown(6'b111111);
        t_unknown(6'b001000);
        t_load(1'b1);
        t_jump();
        t_alu();
        t_exclusive();
        rst = 1'b1;
        step();
        rst = 1'b0;
        check(E_FETCH, "R1 second reset");
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule